// File: doc/BRIEF.md
# Per-Lane Variable-Count Vector Shifter

This unit takes two vectors of up to 128 bits and shifts each lane of the first operand by a count held in the matching lane of the second operand. Each count is a small signed number, so within one operation some lanes can shift left, some can shift right, and some can come out as zero. The caller chooses a lane size of 8, 16, 32 or 64 bits. A signedness select makes right shifts either sign-filling or zero-filling. A width select makes the unit work on the full 128 bits or on the low 64 bits only.

The operands are presented together with a one-cycle start strobe. The shifted vector is captured in an output register, and a valid pulse appears on the cycle after the strobe. The result and the error flag then hold until the next strobe. One combination is illegal: 64-bit lanes in 64-bit register mode. It raises the error flag and produces an all-zero result.

Top module: `lane_shift_unit`

## Requirements
- R1: The count for each lane is bits [7:0] of that lane of `opB`, read as a two's-complement value from -128 to +127. Bits of the `opB` lane above bit 7 have no effect on the result.
- R2: A count from 0 to 127 shifts the `opA` lane left by that many bits. Vacated low bits are filled with zero.
- R3: A negative count shifts the `opA` lane right by its magnitude. The fill is copies of the lane's top bit when `signedOp`=1 and zeros when `signedOp`=0.
- R4: If the shift magnitude is at least the lane width, that lane's result is zero. This holds for left and right shifts and for both signedness settings, and includes the count -128.
- R5: `laneSize` code k selects lanes of 8<<k bits: 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 64. Lane i occupies bits [i*W +: W] of `opA`, `opB` and `shiftOut`.
- R6: When `fullWidth`=0, only bits [63:0] are processed, and bits [127:64] of the result are zero.
- R7: `laneSize`=3 together with `fullWidth`=0 is illegal. It sets `badCombo`=1 and gives an all-zero `shiftOut`. Every legal operation leaves `badCombo`=0.
- R8: `resValid` is 1 for exactly the one cycle that follows each cycle in which `start` is 1. `shiftOut` and `badCombo` change only on those operations and hold their values in between.
- R9: A synchronous reset clears `shiftOut`, `resValid` and `badCombo` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Capture strobe for one operation |
| laneSize | input | 2 | Lane size code (0:8, 1:16, 2:32, 3:64 bits) |
| signedOp | input | 1 | 1: right shifts fill with the sign bit; 0: they fill with zeros |
| fullWidth | input | 1 | 1: 128-bit operation; 0: low 64 bits only |
| opA | input | 128 | Data vector to be shifted |
| opB | input | 128 | Vector whose lanes hold the signed counts |
| shiftOut | output | 128 | Registered result |
| resValid | output | 1 | One-cycle pulse marking a new result |
| badCombo | output | 1 | Registered flag for the illegal size/width combination |

## Verification
The datapath holds no state apart from the output register. A wrong lane boundary, a wrong fill bit or a wrong zero threshold therefore shows up on `shiftOut` in the very cycle that `resValid` pulses for the operation that hits it. The sweep runs every count from -128 to 127 in every lane, for every size, signedness and width. Fault-bearing counts thus reach the port within a single operation. If the control's strobe decode is wrong, the result is a stray or missing `resValid` one cycle after `start`, a nonzero upper half in 64-bit mode, or a `badCombo` value that does not match the size/width pair just issued. All of these are visible at the next sample.

// File: rtl/lane_shift_pkg.sv
package lane_shift_pkg;

  typedef enum logic [1:0] {
    LANE_B8  = 2'd0,
    LANE_B16 = 2'd1,
    LANE_B32 = 2'd2,
    LANE_B64 = 2'd3
  } laneSize_e;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic      capture;    // load the output register
    logic      forceZero;  // illegal combination: all-zero result
    logic      upperZero;  // 64-bit mode: clear the upper half
    logic      signedOp;   // right shifts fill with the sign bit
    laneSize_e size;       // lane size in use
  } shiftCtl_t;

endpackage

// File: rtl/lane_shift_ctrl.sv
module lane_shift_ctrl
  import lane_shift_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  logic [1:0] laneSize,
  input  logic      signedOp,
  input  logic      fullWidth,
  output shiftCtl_t ctl,
  output logic      validOut,
  output logic      errOut
);

  logic illegalCombo;

  always_comb begin
    illegalCombo  = (laneSize_e'(laneSize) == LANE_B64) && !fullWidth;
    ctl.capture   = start;
    ctl.forceZero = illegalCombo;
    ctl.upperZero = !fullWidth;
    ctl.signedOp  = signedOp;
    ctl.size      = laneSize_e'(laneSize);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validOut <= 1'b0;
      errOut   <= 1'b0;
    end else begin
      validOut <= start;
      if (start) errOut <= illegalCombo;
    end
  end

  // R8
  valid_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> validOut);

  // R8
  valid_only_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    validOut |-> $past(start));

  // R7
  err_on_illegal_chk: assert property (@(posedge clk) disable iff (rst)
    (start && laneSize == 2'd3 && !fullWidth) |=> errOut);

  // R7
  err_clear_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !(laneSize == 2'd3 && !fullWidth)) |=> !errOut);

endmodule

// File: rtl/lane_shift_datapath.sv
module lane_shift_datapath
  import lane_shift_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  shiftCtl_t        ctl,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  output logic [VEC_W-1:0] resultReg
);

  localparam int HALF_W    = VEC_W / 2;
  localparam int NUM_SIZES = 4;

  logic [VEC_W-1:0] perSize [NUM_SIZES];
  logic [VEC_W-1:0] nextRes;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : gSize
    localparam int W = 8 << s;
    localparam int N = VEC_W / W;
    for (genvar i = 0; i < N; i++) begin : gLane
      logic [W-1:0] laneA;
      logic [W-1:0] laneR;
      logic [7:0]   cnt;
      logic [8:0]   mag;
      always_comb begin
        laneA = opA[i*W +: W];
        cnt   = opB[i*W +: 8];
        mag   = cnt[7] ? (9'd0 - {1'b1, cnt}) : {1'b0, cnt};
        if (mag >= 9'(W))
          laneR = '0;
        else if (!cnt[7])
          laneR = laneA << mag;
        else if (ctl.signedOp)
          laneR = W'($signed(laneA) >>> mag);
        else
          laneR = laneA >> mag;
      end
      assign perSize[s][i*W +: W] = laneR;
    end
  end

  always_comb begin
    nextRes = perSize[ctl.size];
    if (ctl.upperZero) nextRes[VEC_W-1:HALF_W] = '0;
    if (ctl.forceZero) nextRes = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) resultReg <= '0;
    else if (ctl.capture) resultReg <= nextRes;
  end

  // R8
  hold_between_ops_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.capture |=> $stable(resultReg));

  // R6
  upper_half_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.capture && ctl.upperZero) |=> (resultReg[VEC_W-1:HALF_W] == '0));

  // R7
  illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.capture && ctl.forceZero) |=> (resultReg == '0));

endmodule

// File: rtl/lane_shift_unit.sv
module lane_shift_unit
  import lane_shift_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       laneSize,
  input  logic             signedOp,
  input  logic             fullWidth,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  output logic [VEC_W-1:0] shiftOut,
  output logic             resValid,
  output logic             badCombo
);

  shiftCtl_t ctl;

  lane_shift_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .laneSize (laneSize),
    .signedOp (signedOp),
    .fullWidth(fullWidth),
    .ctl      (ctl),
    .validOut (resValid),
    .errOut   (badCombo)
  );

  lane_shift_datapath #(.VEC_W(VEC_W)) uPath (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .opA      (opA),
    .opB      (opB),
    .resultReg(shiftOut)
  );

  // R9
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!resValid && !badCombo && shiftOut == '0));

endmodule

// File: tb/lane_shift_unit_test.sv
module lane_shift_unit_test;

  localparam int CYC = 5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [1:0]   laneSize = 2'd0;
  logic         signedOp = 1'b0;
  logic         fullWidth = 1'b1;
  logic [127:0] opA = '0;
  logic [127:0] opB = '0;
  logic [127:0] shiftOut;
  logic         resValid;
  logic         badCombo;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CYC/2.0) clk = ~clk;

  lane_shift_unit uut (
    .clk(clk), .rst(rst), .start(start), .laneSize(laneSize),
    .signedOp(signedOp), .fullWidth(fullWidth), .opA(opA), .opB(opB),
    .shiftOut(shiftOut), .resValid(resValid), .badCombo(badCombo)
  );

  function automatic logic [127:0] refVec(logic [127:0] a, logic [127:0] b,
                                          int size, bit sgn, bit wide);
    logic [127:0] res = '0;
    int w = 8 << size;
    int n = (wide ? 128 : 64) / w;
    logic [127:0] mask = (128'd1 << w) - 128'd1;
    if (!wide && size == 3) return '0;
    for (int i = 0; i < n; i++) begin
      logic [127:0] la = (a >> (i * w)) & mask;
      logic [7:0] cb = b[i*8*(1<<size) +: 8];
      int c = int'($signed(cb));
      int m = (c < 0) ? -c : c;
      logic [127:0] r;
      logic [127:0] p2;
      if (m >= w) r = '0;
      else begin
        p2 = 128'd1 << m;
        if (c >= 0) r = (la * p2) & mask;
        else if (sgn && la[w-1]) r = (~(((~la) & mask) / p2)) & mask;
        else r = la / p2;
      end
      res = res | (r << (i * w));
    end
    return res;
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runOp(logic [127:0] a, logic [127:0] b, int size, bit sgn, bit wide);
    @(negedge clk);
    opA = a; opB = b; laneSize = 2'(size); signedOp = sgn; fullWidth = wide;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    repeat (4) @(negedge clk);
    // R9 reset state
    check("R9 reset result", shiftOut, '0);
    check("R9 reset valid", {127'd0, resValid}, 128'd0);
    check("R9 reset err", {127'd0, badCombo}, 128'd0);
    rst = 1'b0;

    // R1 R2 R3 R4 R5 R6 sweep over every count in every lane
    for (int wide = 0; wide < 2; wide++)
      for (int sgn = 0; sgn < 2; sgn++)
        for (int size = 0; size < 4; size++) begin
          if (!(wide == 0 && size == 3))
            for (int base = 0; base < 256; base++) begin
              logic [127:0] a = {$urandom, $urandom, $urandom, $urandom};
              logic [127:0] b = {$urandom, $urandom, $urandom, $urandom};
              int w = 8 << size;
              if (base[0]) a = a | {16{8'h80}};
              for (int i = 0; i < 128 / w; i++)
                b[i*w +: 8] = 8'((base + 29 * i) & 255);
              runOp(a, b, size, sgn[0], wide[0]);
              check("R1 R2 R3 R4 R5 R6 sweep", shiftOut,
                    refVec(a, b, size, sgn[0], wide[0]));
              if (resValid !== 1'b1 || badCombo !== 1'b0) begin
                total++; bad++;
                $display("FAIL R8 R7 flags: actual=%b%b expected=10", resValid, badCombo);
              end
            end
        end

    // R4 directed extremes on 8-bit lanes: counts 8, -8, -128, 127
    runOp({16{8'hF0}}, {{12{8'h00}}, 8'h7F, 8'h80, 8'hF8, 8'h08}, 0, 1'b1, 1'b1);
    check("R4 extremes", shiftOut, {{12{8'hF0}}, 32'h0});

    // R3 signed vs unsigned fill, 16-bit lanes, count -4
    runOp({8{16'h8010}}, {8{16'h00FC}}, 1, 1'b1, 1'b1);
    check("R3 arithmetic fill", shiftOut, {8{16'hF801}});
    runOp({8{16'h8010}}, {8{16'h00FC}}, 1, 1'b0, 1'b1);
    check("R3 logical fill", shiftOut, {8{16'h0801}});

    // R1 high count bits ignored: opB lane 0x5501 acts as +1
    runOp({8{16'h0101}}, {8{16'h5501}}, 1, 1'b0, 1'b1);
    check("R1 upper bits ignored", shiftOut, {8{16'h0202}});

    // R7 illegal combination
    runOp({4{32'hDEADBEEF}}, '0, 3, 1'b0, 1'b0);
    check("R7 illegal zero", shiftOut, '0);
    check("R7 illegal flag", {127'd0, badCombo}, 128'd1);
    runOp({4{32'h1}}, '0, 3, 1'b0, 1'b1);
    check("R7 legal 64-bit lanes", shiftOut, {4{32'h1}});
    check("R7 flag cleared", {127'd0, badCombo}, 128'd0);

    // R8 pulse width and hold
    held = shiftOut;
    @(negedge clk);
    check("R8 valid single pulse", {127'd0, resValid}, 128'd0);
    opA = '1; opB = '0; laneSize = 2'd0;
    repeat (3) @(negedge clk);
    check("R8 hold result", shiftOut, held);
    check("R8 hold valid", {127'd0, resValid}, 128'd0);

    // R9 reset after a nonzero result
    runOp({16{8'h11}}, '0, 0, 1'b0, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check("R9 mid reset result", shiftOut, '0);
    check("R9 mid reset valid", {127'd0, resValid}, 128'd0);
    rst = 1'b0;

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule